// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex transmitter and receiver for asynchronous serial characters. Parallel bytes enter through a valid/ready port and leave the line one bit at a time; the receiver gathers bits from the incoming line and presents each character with its own status flags on a second valid/ready port. The character format can change at run time. It sets the data length (5 to 8 bits), the number of stop bits, and whether parity is used and whether it is even or odd.

The bit rate comes from a shared generator that emits a tick at sixteen times the bit rate. A 16-bit divisor sets the tick rate. The divisor counts either every master clock or every second master clock. The receiver samples each bit at the centre of its sixteen ticks. It discards a start edge that does not last to mid-bit. It flags framing errors, parity errors and a line held low for a whole character. The transmitter can force the line low on request to send a break.

Top module: `serxcvr`

## Requirements
- R1: A character is sent and received as a low start bit and then `5 + cfgWordLen` data bits, least significant bit first (cfgWordLen 0..3 selects 5..8 bits). Transmit data bits above the selected length are ignored, and receive data bits above it read as zero.
- R2: After the data (and parity) the transmitter drives one high stop bit, or two when cfgStop2 is 1. It accepts no new byte before the last stop bit has started.
- R3: With cfgParEn set, a parity bit follows the data bits. It makes the count of ones in data plus parity even when cfgParOdd is 0, and odd when cfgParOdd is 1. With cfgParEn clear, no parity bit is sent.
- R4: The receiver raises rxParityErr with the character when the received parity bit disagrees with the configured parity. The flag stays low when parity is disabled.
- R5: The receiver raises rxFrameErr when the first stop bit is sampled low, and it returns a nonzero character unchanged.
- R6: A character whose data bits, parity bit and first stop bit are all low is reported with rxBreak and rxFrameErr set and rxData zero. The receiver then waits for the line to go high before it hunts for a new start bit.
- R7: A low pulse on the receive line that has ended by mid-bit produces no character, and the receiver returns to idle.
- R8: One bit lasts 16 × cfgDivisor master clocks, or 32 × cfgDivisor when cfgClkHalf is 1. A divisor of 0 acts as 1.
- R9: While txBreak is high, txLine is low from the next clock on and txReady is low, so an offered byte is not taken. After txBreak is released the line returns high.
- R10: rxValid stays high until rxReady is seen with it. A character completed before that replaces the held one.
- R11: After reset, txLine is high, txReady is high and rxValid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock |
| rstN | input | 1 | active-low synchronous reset |
| cfgDivisor | input | 16 | oversampling tick divisor (0 acts as 1) |
| cfgClkHalf | input | 1 | 1: divisor counts every second clock |
| cfgWordLen | input | 2 | data bits minus five |
| cfgStop2 | input | 1 | 1: transmit two stop bits |
| cfgParEn | input | 1 | parity bit present |
| cfgParOdd | input | 1 | 1: odd parity, 0: even parity |
| txBreak | input | 1 | hold the transmit line low |
| txData | input | 8 | byte to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | transmitter takes the offered byte |
| txLine | output | 1 | serial output, idle high |
| rxLine | input | 1 | serial input, idle high, asynchronous |
| rxData | output | 8 | received character |
| rxValid | output | 1 | rxData and flags are held for the consumer |
| rxReady | input | 1 | consumer takes the held character |
| rxFrameErr | output | 1 | first stop bit was low |
| rxParityErr | output | 1 | parity mismatch |
| rxBreak | output | 1 | whole character time was low |

## Verification
The hardest cases to reach from the ports are the ones that depend on the receiver's internal tick phase: a start pulse that ends just before the mid-bit sample, and a break that must end in the wait-for-high state rather than a new start. The bench drives the receive line itself, with its bit period computed from the divisor. It makes the false start a quarter-bit pulse and the break a line held low across the whole frame. It then proves recovery with a clean character right after. The divide-by-two reference is reached by looping the transmit line into the receiver, so both directions run on the slower tick at once.

// File: rtl/serxcvr_pkg.sv
package serxcvr_pkg;

  typedef enum logic [1:0] {LEN5 = 2'd0, LEN6, LEN7, LEN8} wordLen_e;

  typedef struct packed {
    wordLen_e len;
    logic     stop2;
    logic     parEn;
    logic     parOdd;
  } frameCfg_t;

  typedef enum logic [2:0] {TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_PAR, TX_STOP} txState_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rxState_e;

  localparam int OVERSAMPLE = 16;
  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);

  function automatic logic [3:0] bitsOf(wordLen_e l);
    return 4'd5 + {2'b00, l};
  endfunction

  function automatic logic [7:0] maskOf(wordLen_e l);
    return 8'hFF >> (4'd8 - bitsOf(l));
  endfunction

  function automatic logic parityOf(logic [7:0] d, wordLen_e l, logic odd);
    return (^(d & maskOf(l))) ^ odd;
  endfunction

endpackage

// File: rtl/serxcvr_baud.sv
module serxcvr_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             halfRef,
  output logic             tick
);
  logic             halfPhase;
  logic             refEn;
  logic [DIV_W-1:0] cnt;

  assign refEn = !halfRef || halfPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPhase <= 1'b0;
      cnt       <= '0;
      tick      <= 1'b0;
    end else begin
      halfPhase <= halfRef ? ~halfPhase : 1'b0;
      tick      <= 1'b0;
      if (refEn) begin
        if (cnt == '0) begin
          tick <= 1'b1;
          cnt  <= (divisor == '0) ? '0 : divisor - 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_HALF_REF_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (halfRef && tick) |=> !tick); // R8

endmodule

// File: rtl/serxcvr_tx.sv
module serxcvr_tx
  import serxcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  frameCfg_t  cfg,
  input  logic       brk,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line
);
  txState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic [2:0]       lastIdx;
  logic [7:0]       shreg;
  logic             parBit;
  logic             parEnQ;
  logic             stop2Q;
  logic             stopLeft;
  logic             bitVal;

  assign ready = (state == TX_IDLE) && !brk;

  always_comb begin
    case (state)
      TX_START: bitVal = 1'b0;
      TX_DATA:  bitVal = shreg[0];
      TX_PAR:   bitVal = parBit;
      default:  bitVal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= TX_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      lastIdx  <= '0;
      shreg    <= '0;
      parBit   <= 1'b0;
      parEnQ   <= 1'b0;
      stop2Q   <= 1'b0;
      stopLeft <= 1'b0;
      line     <= 1'b1;
    end else begin
      line <= bitVal && !brk;
      if (valid && ready) begin
        shreg   <= data;
        parBit  <= parityOf(data, cfg.len, cfg.parOdd);
        lastIdx <= 3'(bitsOf(cfg.len) - 4'd1);
        parEnQ  <= cfg.parEn;
        stop2Q  <= cfg.stop2;
        state   <= TX_WAIT;
      end else if (tick) begin
        if (state == TX_WAIT) begin
          state <= TX_START;
          cnt   <= '0;
        end else if (state != TX_IDLE) begin
          if (cnt == LAST_TICK) begin
            cnt <= '0;
            case (state)
              TX_START: begin
                state  <= TX_DATA;
                bitIdx <= '0;
              end
              TX_DATA: begin
                if (bitIdx == lastIdx) begin
                  state    <= parEnQ ? TX_PAR : TX_STOP;
                  stopLeft <= stop2Q;
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                  shreg  <= {1'b0, shreg[7:1]};
                end
              end
              TX_PAR: begin
                state    <= TX_STOP;
                stopLeft <= stop2Q;
              end
              TX_STOP: begin
                if (stopLeft) stopLeft <= 1'b0;
                else          state    <= TX_IDLE;
              end
              default: ;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_TX_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready) |=> !ready); // R2

  AST_TX_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(brk)) |-> !line); // R9

  AST_TX_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(state == TX_IDLE) && !$past(brk)) |-> line); // R11

endmodule

// File: rtl/serxcvr_rx.sv
module serxcvr_rx
  import serxcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  wordLen_e   len,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic       line,
  input  logic       rdy,
  output logic       valid,
  output logic [7:0] data,
  output logic       frameErr,
  output logic       parErr,
  output logic       brk
);
  logic             syncA;
  logic             syncB;
  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic [2:0]       lastIdx;
  wordLen_e         lenQ;
  logic             parEnQ;
  logic             parOddQ;
  logic [7:0]       shreg;
  logic             anyOne;
  logic             parSample;
  logic [7:0]       assembled;
  logic             parBad;

  assign assembled = shreg >> (4'd8 - bitsOf(lenQ));
  assign parBad    = parEnQ && (parSample != parityOf(assembled, lenQ, parOddQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= 1'b1;
      syncB     <= 1'b1;
      state     <= RX_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      lastIdx   <= '0;
      lenQ      <= LEN8;
      parEnQ    <= 1'b0;
      parOddQ   <= 1'b0;
      shreg     <= '0;
      anyOne    <= 1'b0;
      parSample <= 1'b0;
      valid     <= 1'b0;
      data      <= '0;
      frameErr  <= 1'b0;
      parErr    <= 1'b0;
      brk       <= 1'b0;
    end else begin
      syncA <= line;
      syncB <= syncA;
      if (valid && rdy) valid <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!syncB) begin
              state     <= RX_START;
              cnt       <= '0;
              lenQ      <= len;
              lastIdx   <= 3'(bitsOf(len) - 4'd1);
              parEnQ    <= parEn;
              parOddQ   <= parOdd;
              shreg     <= '0;
              anyOne    <= 1'b0;
              parSample <= 1'b0;
            end
          end
          RX_START: begin
            if (cnt == MID_TICK) begin
              cnt <= '0;
              if (syncB) begin
                state <= RX_IDLE;
              end else begin
                state  <= RX_DATA;
                bitIdx <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST_TICK) begin
              cnt    <= '0;
              shreg  <= {syncB, shreg[7:1]};
              anyOne <= anyOne | syncB;
              if (bitIdx == lastIdx) state <= parEnQ ? RX_PAR : RX_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt == LAST_TICK) begin
              cnt       <= '0;
              parSample <= syncB;
              state     <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST_TICK) begin
              cnt      <= '0;
              valid    <= 1'b1;
              data     <= assembled;
              frameErr <= !syncB;
              parErr   <= parBad;
              brk      <= !syncB && !anyOne && !parSample;
              state    <= syncB ? RX_IDLE : RX_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_WAITHI: begin
            if (syncB) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_BREAK_IMPLIES_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    (valid && brk) |-> frameErr); // R6

  AST_RX_BREAK_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (valid && brk) |-> (data == 8'h00)); // R6

  AST_RX_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !rdy) |=> valid); // R10

endmodule

// File: rtl/serxcvr.sv
module serxcvr
  import serxcvr_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             cfgClkHalf,
  input  logic [1:0]       cfgWordLen,
  input  logic             cfgStop2,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             txBreak,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txLine,
  input  logic             rxLine,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             rxFrameErr,
  output logic             rxParityErr,
  output logic             rxBreak
);
  logic      tick;
  frameCfg_t cfg;

  assign cfg = '{len: wordLen_e'(cfgWordLen), stop2: cfgStop2,
                 parEn: cfgParEn, parOdd: cfgParOdd};

  serxcvr_baud #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (cfgDivisor),
    .halfRef (cfgClkHalf),
    .tick    (tick)
  );

  serxcvr_tx tx_i (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .cfg   (cfg),
    .brk   (txBreak),
    .data  (txData),
    .valid (txValid),
    .ready (txReady),
    .line  (txLine)
  );

  serxcvr_rx rx_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .len      (cfg.len),
    .parEn    (cfg.parEn),
    .parOdd   (cfg.parOdd),
    .line     (rxLine),
    .rdy      (rxReady),
    .valid    (rxValid),
    .data     (rxData),
    .frameErr (rxFrameErr),
    .parErr   (rxParityErr),
    .brk      (rxBreak)
  );

endmodule

// File: tb/serxcvr_tb_top.sv
module serxcvr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgDivisor = 16'd2;
  logic        cfgClkHalf = 1'b0;
  logic [1:0]  cfgWordLen = 2'd3;
  logic        cfgStop2 = 1'b0;
  logic        cfgParEn = 1'b0;
  logic        cfgParOdd = 1'b0;
  logic        txBreak = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady;
  logic        txLine;
  logic        rxLine;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b0;
  logic        rxFrameErr;
  logic        rxParityErr;
  logic        rxBreak;
  logic        loopOn = 1'b0;
  logic        rxDrv = 1'b1;

  int checks = 0;
  int errors = 0;
  int bitP = 32;

  assign rxLine = loopOn ? txLine : rxDrv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serxcvr dut_i (
    .clk(clk), .rstN(rstN), .cfgDivisor(cfgDivisor), .cfgClkHalf(cfgClkHalf),
    .cfgWordLen(cfgWordLen), .cfgStop2(cfgStop2), .cfgParEn(cfgParEn),
    .cfgParOdd(cfgParOdd), .txBreak(txBreak), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLine(txLine), .rxLine(rxLine), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr), .rxBreak(rxBreak)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int dv, input bit half, input int wl, input bit s2, input bit pe, input bit po);
    @(negedge clk);
    cfgDivisor = 16'(dv);
    cfgClkHalf = half;
    cfgWordLen = 2'(wl);
    cfgStop2   = s2;
    cfgParEn   = pe;
    cfgParOdd  = po;
    bitP = 16 * ((dv == 0) ? 1 : dv) * (half ? 2 : 1);
  endtask

  function automatic bit refParity(input logic [7:0] d, input int n, input bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    return bit'(ones % 2) ^ odd;
  endfunction

  // Offer a byte, then check every bit of the resulting frame at its centre.
  task automatic txFrame(input logic [7:0] d, input string req);
    int n = 5 + int'(cfgWordLen);
    int guard = 0;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    while (txLine && guard < 20 * bitP) begin
      @(negedge clk);
      guard++;
    end
    repeat (bitP / 2) @(negedge clk);
    chk(req, "start bit", 32'(txLine), 32'd0);
    for (int i = 0; i < n; i++) begin
      repeat (bitP) @(negedge clk);
      chk(req, $sformatf("data bit %0d", i), 32'(txLine), 32'(d[i]));
    end
    if (cfgParEn) begin
      repeat (bitP) @(negedge clk);
      chk("R3", "parity bit", 32'(txLine), 32'(refParity(d, n, cfgParOdd)));
    end
    repeat (bitP) @(negedge clk);
    chk("R2", "stop bit 1", 32'(txLine), 32'd1);
    if (cfgStop2) begin
      repeat (bitP) @(negedge clk);
      chk("R2", "stop bit 2", 32'(txLine), 32'd1);
    end
  endtask

  // Drive a frame on the receive line; optionally check and acknowledge.
  task automatic rxFrame(input logic [7:0] d, input bit badPar, input bit stopLow,
                         input bit doCheck, input bit doAck, input string req);
    int n = 5 + int'(cfgWordLen);
    bit pb = refParity(d, n, cfgParOdd) ^ badPar;
    logic [7:0] expD = d & (8'hFF >> (8 - n));
    bit expBrk = stopLow && (expD == 8'h00) && (!cfgParEn || !pb);
    @(negedge clk);
    rxDrv = 1'b0;
    repeat (bitP) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxDrv = d[i];
      repeat (bitP) @(negedge clk);
    end
    if (cfgParEn) begin
      rxDrv = pb;
      repeat (bitP) @(negedge clk);
    end
    rxDrv = !stopLow;
    repeat (bitP) @(negedge clk);
    rxDrv = 1'b1;
    if (cfgStop2) repeat (bitP) @(negedge clk);
    if (doCheck) begin
      chk(req, "rxValid", 32'(rxValid), 32'd1);
      chk(req, "rxData", 32'(rxData), 32'(expD));
      chk("R4", "rxParityErr", 32'(rxParityErr), 32'(cfgParEn && badPar));
      chk("R5", "rxFrameErr", 32'(rxFrameErr), 32'(stopLow));
      chk("R6", "rxBreak", 32'(rxBreak), 32'(expBrk));
    end
    if (doAck) begin
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
      chk("R10", "rxValid cleared by ready", 32'(rxValid), 32'd0);
    end
    repeat (bitP) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "txLine idle", 32'(txLine), 32'd1);
    chk("R11", "txReady", 32'(txReady), 32'd1);
    chk("R11", "rxValid", 32'(rxValid), 32'd0);

    // Transmit formats (R1, R2, R3)
    setCfg(2, 0, 3, 0, 0, 0);
    txFrame(8'hA5, "R1");
    setCfg(2, 0, 0, 0, 0, 0);
    txFrame(8'hF6, "R1");
    setCfg(2, 0, 2, 1, 1, 0);
    txFrame(8'h6B, "R3");
    setCfg(2, 0, 1, 0, 1, 1);
    txFrame(8'h2C, "R3");

    // Receive formats
    setCfg(2, 0, 3, 0, 0, 0);
    rxFrame(8'h5A, 0, 0, 1, 1, "R1");
    setCfg(2, 0, 0, 0, 0, 0);
    rxFrame(8'hF3, 0, 0, 1, 1, "R1");
    setCfg(2, 0, 3, 0, 1, 0);
    rxFrame(8'h37, 1, 0, 1, 1, "R4");
    setCfg(2, 0, 2, 1, 1, 1);
    rxFrame(8'h4D, 0, 0, 1, 1, "R3");
    setCfg(2, 0, 3, 0, 0, 0);
    rxFrame(8'h81, 0, 1, 1, 1, "R5");
    rxFrame(8'h00, 0, 1, 1, 1, "R6");
    rxFrame(8'h96, 0, 0, 1, 1, "R6");

    // R7: false start
    @(negedge clk);
    rxDrv = 1'b0;
    repeat (bitP / 4) @(negedge clk);
    rxDrv = 1'b1;
    repeat (3 * bitP) @(negedge clk);
    chk("R7", "no character after short pulse", 32'(rxValid), 32'd0);
    rxFrame(8'h3C, 0, 0, 1, 1, "R7");

    // R10: held then replaced
    rxFrame(8'h11, 0, 0, 0, 0, "R10");
    chk("R10", "rxValid held", 32'(rxValid), 32'd1);
    rxFrame(8'hE2, 0, 0, 1, 1, "R10");

    // R8: halved reference, loopback into the receiver
    setCfg(3, 1, 3, 0, 0, 0);
    loopOn = 1'b1;
    txFrame(8'hC3, "R8");
    repeat (bitP) @(negedge clk);
    chk("R8", "loopback rxValid", 32'(rxValid), 32'd1);
    chk("R8", "loopback rxData", 32'(rxData), 32'hC3);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    loopOn = 1'b0;
    setCfg(0, 0, 3, 0, 0, 0);
    txFrame(8'h3A, "R8");

    // R9: transmit break
    setCfg(2, 0, 3, 0, 0, 0);
    repeat (2 * bitP) @(negedge clk);
    txBreak = 1'b1;
    txData = 8'h55;
    txValid = 1'b1;
    @(negedge clk);
    chk("R9", "line low in break", 32'(txLine), 32'd0);
    chk("R9", "txReady low in break", 32'(txReady), 32'd0);
    repeat (3 * bitP) @(negedge clk);
    chk("R9", "line still low", 32'(txLine), 32'd0);
    txValid = 1'b0;
    txBreak = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "line high after release", 32'(txLine), 32'd1);
    chk("R9", "txReady after release", 32'(txReady), 32'd1);
    begin
      bit sawLow = 1'b0;
      for (int i = 0; i < 2 * bitP; i++) begin
        @(negedge clk);
        if (!txLine) sawLow = 1'b1;
      end
      chk("R9", "offered byte not sent", 32'(sawLow), 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule